// File: doc/BRIEF.md
# Pseudo-DMA Wait-State Generator

This block stretches processor bus cycles that address the data port of a SCSI controller used in pseudo-DMA mode. When such a cycle starts, the block pulls the active-low not-ready line low. It holds the line low until the selected controller raises its DMA request and a fixed number of wait-state clocks have passed. It then lets the line go high, so the processor moves exactly one byte per access and never reads a byte that the controller has not yet produced.

Two controllers share the block, and a select input decides whose request and interrupt lines it uses. An interrupt from the selected controller means the transfer has failed. That interrupt releases the stalled cycle at once and latches a sticky abort, so every later access of the transfer completes without waiting and the driver can service the interrupt. Writing the transfer-setup strobe, or resetting the block, clears the abort. A stall has no time limit, and the block has no link to memory refresh, which is arbitrated elsewhere.

Top module: `pdma_wait_gen`

## Requirements
- R1: While a pseudo-DMA cycle is active (`bus_strobe_i` and `port_hit_i` both high), there is no abort, and the selected request has not been seen, `nrdy_o` is low from the start of the cycle. There is no timeout: with no request, a stall of any length keeps `nrdy_o` low.
- R2: Request inputs pass through a two-flop synchronizer. The first rising clock edge at which the synchronized selected request is high is the seen edge. `nrdy_o` goes high after the second rising edge that follows the seen edge. If the request is raised at the falling edge d cycles after the falling edge that starts the cycle, the release follows rising edge max(3, d+5). A request that has been high for three or more cycles before the cycle starts gives a release after edge 3.
- R3: `ctl_sel_i` = 0 takes the request and interrupt from index 0 of `ctl_dreq_i`/`ctl_irq_i`, and 1 takes them from index 1. The lines of the controller that is not selected have no effect on `nrdy_o`.
- R4: When the synchronized selected interrupt is high, `nrdy_o` is high in that same cycle. An interrupt raised k falling edges after the cycle starts releases the cycle after rising edge k+2, even during the wait-state count.
- R5: After an interrupt, a sticky abort keeps `nrdy_o` high for every later access, whatever the select or request inputs do, even once the interrupt has dropped.
- R6: A high `setup_wr_i` at a rising edge clears the abort, and normal waiting resumes. A synchronized interrupt in the same cycle wins and keeps the abort set.
- R7: When no pseudo-DMA cycle is active (strobe low or address not decoded), `nrdy_o` is high.
- R8: The wait count restarts for each access. After a released access, the next access waits for a fresh request and does not reuse the previous one.
- R9: Asynchronous active-low reset, released synchronously: it clears the abort and the wait state, and `nrdy_o` is high while reset is held with no cycle active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_strobe_i | input | 1 | High while a bus cycle is in progress |
| port_hit_i | input | 1 | Address decodes to the pseudo-DMA data port |
| ctl_sel_i | input | SEL_W (1) | Selects which controller's lines are used |
| ctl_dreq_i | input | NCTL (2) | DMA request, one bit per controller, active high |
| ctl_irq_i | input | NCTL (2) | Interrupt, one bit per controller, active high |
| setup_wr_i | input | 1 | Transfer-setup strobe, clears the abort |
| nrdy_o | output | 1 | Not-ready to the processor, active low |

## Verification
The start of a stall and an interrupt release are combinational from the cycle inputs and the synchronizer output, so the bench reads `nrdy_o` one time step after it drives a new cycle. Every later result is counted in rising edges from the falling edge that opened the cycle. A request raised at offset d is due after edge max(3, d+5), an interrupt at offset k after edge k+2, and a setup strobe takes effect at the next edge. The bench drives and samples only at falling edges and records the first falling edge at which `nrdy_o` is high. It compares that edge number with the value its own function computes from these rules, so a release that comes one edge early or late is reported.

// File: rtl/pdma_wait_pkg.sv
`timescale 1ns/1ps
package pdma_wait_pkg;

  // Per-access stall sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no pseudo-DMA cycle in progress
    ST_WAIT  = 2'd1,  // cycle open, request not yet seen
    ST_COUNT = 2'd2,  // request seen, counting wait states
    ST_READY = 2'd3   // wait states done, cycle released
  } stall_st_e;

endpackage

// File: rtl/pdma_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module pdma_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= 2'b00;
    end else begin
      rel_q <= {rel_q[0], 1'b1};
    end
  end

  assign rst_no = rel_q[1];

endmodule

// File: rtl/pdma_sync_bank.sv
`timescale 1ns/1ps
// Bank of multi-stage synchronizers, one chain per input bit.
module pdma_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '0;
        end else begin
          chain_q <= d_i[b];
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          chain_q <= '0;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
      end
    end

    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pdma_src_sel.sv
`timescale 1ns/1ps
// Picks the request and interrupt of the selected controller.
module pdma_src_sel #(
  parameter int NCTL  = 2,
  parameter int SEL_W = 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NCTL-1:0]  dreq_i,
  input  logic [NCTL-1:0]  irq_i,
  output logic             dreq_o,
  output logic             irq_o
);

  always_comb begin
    dreq_o = 1'b0;
    irq_o  = 1'b0;
    for (int i = 0; i < NCTL; i++) begin
      if (sel_i == SEL_W'(i)) begin
        dreq_o = dreq_i[i];
        irq_o  = irq_i[i];
      end
    end
  end

endmodule

// File: rtl/pdma_abort_latch.sv
`timescale 1ns/1ps
// Sticky abort set by the selected interrupt, cleared by the setup strobe.
module pdma_abort_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic abort_q_o,
  output logic abort_any_o
);

  logic abort_q;
  logic abort_d;
  logic abort_en;

  // Interrupt has priority over the clear strobe
  always_comb begin
    abort_en = irq_i | clr_i;
    abort_d  = abort_q;
    if (irq_i) begin
      abort_d = 1'b1;
    end else if (clr_i) begin
      abort_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
    end else if (abort_en) begin
      abort_q <= abort_d;
    end
  end

  assign abort_q_o   = abort_q;
  // Live interrupt releases in the same cycle, before the flag is set
  assign abort_any_o = abort_q | irq_i;

endmodule

// File: rtl/pdma_stall_fsm.sv
`timescale 1ns/1ps
// Per-access sequencer: wait for request, then count fixed wait states.
module pdma_stall_fsm
  import pdma_wait_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic req_i,
  output logic release_o,
  output logic idle_o
);

  localparam int                CNT_W    = $clog2(WAIT_STATES + 1) + 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(WAIT_STATES);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam stall_st_e         ST_SEEN  = (WAIT_STATES == 0) ? ST_READY : ST_COUNT;

  stall_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seq_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    seq_en = act_i | (st_q != ST_IDLE);
    unique case (st_q)
      ST_IDLE, ST_WAIT: begin
        if (!act_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (req_i) begin
          st_d  = ST_SEEN;
          cnt_d = CNT_ONE;
        end else begin
          st_d  = ST_WAIT;
        end
      end
      ST_COUNT: begin
        if (!act_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          st_d  = ST_READY;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      ST_READY: begin
        if (!act_i) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign release_o = (st_q == ST_READY);
  assign idle_o    = (st_q == ST_IDLE);

endmodule

// File: rtl/pdma_wait_gen.sv
`timescale 1ns/1ps
// Top: pseudo-DMA wait-state generator.
module pdma_wait_gen #(
  parameter int NCTL        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_STATES = 2,
  localparam int SEL_W      = (NCTL > 1) ? $clog2(NCTL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_strobe_i,
  input  logic             port_hit_i,
  input  logic [SEL_W-1:0] ctl_sel_i,
  input  logic [NCTL-1:0]  ctl_dreq_i,
  input  logic [NCTL-1:0]  ctl_irq_i,
  input  logic             setup_wr_i,
  output logic             nrdy_o
);

  logic            rst_n_s;
  logic [NCTL-1:0] dreq_s;
  logic [NCTL-1:0] irq_s;
  logic            dreq_sel_s;
  logic            irq_sel_s;
  logic            cyc_act;
  logic            stall_rel;
  logic            fsm_idle;
  logic            abort_q;
  logic            abort_any;

  assign cyc_act = bus_strobe_i & port_hit_i;

  pdma_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  pdma_sync_bank #(
    .WIDTH  (2 * NCTL),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .d_i    ({ctl_irq_i, ctl_dreq_i}),
    .q_o    ({irq_s, dreq_s})
  );

  pdma_src_sel #(
    .NCTL  (NCTL),
    .SEL_W (SEL_W)
  ) u_src_sel (
    .sel_i  (ctl_sel_i),
    .dreq_i (dreq_s),
    .irq_i  (irq_s),
    .dreq_o (dreq_sel_s),
    .irq_o  (irq_sel_s)
  );

  pdma_stall_fsm #(
    .WAIT_STATES (WAIT_STATES)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .act_i     (cyc_act),
    .req_i     (dreq_sel_s),
    .release_o (stall_rel),
    .idle_o    (fsm_idle)
  );

  pdma_abort_latch u_abort (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .irq_i       (irq_sel_s),
    .clr_i       (setup_wr_i),
    .abort_q_o   (abort_q),
    .abort_any_o (abort_any)
  );

  // Stall only inside an active cycle, until released or aborted
  assign nrdy_o = ~(cyc_act & ~stall_rel & ~abort_any);

endmodule

// File: rtl/pdma_wait_gen_chk.sv
`timescale 1ns/1ps
// Property checker attached to the top module.
module pdma_wait_gen_chk #(
  parameter int WAIT_STATES = 2
) (
  input logic clk_i,
  input logic rst_n_s,
  input logic cyc_act,
  input logic dreq_sel_s,
  input logic irq_sel_s,
  input logic abort_q,
  input logic setup_wr_i,
  input logic fsm_idle,
  input logic nrdy_o
);

  localparam int               SW      = $clog2(WAIT_STATES + 2) + 1;
  localparam logic [SW-1:0]    SEEN_MAX = SW'(WAIT_STATES + 1);

  logic [SW-1:0] seen_q;
  logic          abort_live;

  assign abort_live = abort_q | irq_sel_s;

  // Independent count of edges since the request was first seen in this cycle
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      seen_q <= '0;
    end else if (!cyc_act) begin
      seen_q <= '0;
    end else if (seen_q == '0) begin
      if (dreq_sel_s) seen_q <= SW'(1);
    end else if (seen_q < SEEN_MAX) begin
      seen_q <= seen_q + SW'(1);
    end
  end

  p_stall_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cyc_act && !abort_live && seen_q <= SW'(WAIT_STATES)) |-> !nrdy_o);

  p_release_due_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cyc_act && seen_q == SEEN_MAX) |-> nrdy_o);

  p_irq_release_r4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cyc_act && irq_sel_s) |-> nrdy_o);

  p_abort_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (abort_q && !setup_wr_i) |=> abort_q);

  p_abort_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (setup_wr_i && !irq_sel_s) |=> !abort_q);

  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !cyc_act |-> nrdy_o);

  p_fresh_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !cyc_act |=> fsm_idle);

endmodule

bind pdma_wait_gen pdma_wait_gen_chk #(
  .WAIT_STATES (WAIT_STATES)
) u_chk (
  .clk_i      (clk_i),
  .rst_n_s    (rst_n_s),
  .cyc_act    (cyc_act),
  .dreq_sel_s (dreq_sel_s),
  .irq_sel_s  (irq_sel_s),
  .abort_q    (abort_q),
  .setup_wr_i (setup_wr_i),
  .fsm_idle   (fsm_idle),
  .nrdy_o     (nrdy_o)
);

// File: tb/pdma_wait_gen_bench.sv
`timescale 1ns/1ps
module pdma_wait_gen_bench;

  localparam int NCTL     = 2;
  localparam int REQ_PRE  = -1;  // request raised well before the cycle
  localparam int REQ_NONE = -2;  // no request during the access
  localparam int IRQ_NONE = -1;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic            bus_strobe;
  logic            port_hit;
  logic [0:0]      ctl_sel;
  logic [NCTL-1:0] ctl_dreq;
  logic [NCTL-1:0] ctl_irq;
  logic            setup_wr;
  logic            nrdy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pdma_wait_gen u_pdma_wait_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bus_strobe_i (bus_strobe),
    .port_hit_i   (port_hit),
    .ctl_sel_i    (ctl_sel),
    .ctl_dreq_i   (ctl_dreq),
    .ctl_irq_i    (ctl_irq),
    .setup_wr_i   (setup_wr),
    .nrdy_o       (nrdy)
  );

  task automatic check_int(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected release edge from the requirements; -1 means no release
  function automatic int exp_rel(input int req_at, input int irq_at, input bit aborted);
    int r;
    if (aborted) return 0;
    if (req_at == REQ_NONE)     r = -1;
    else if (req_at == REQ_PRE) r = 3;
    else                        r = (req_at + 5 > 3) ? req_at + 5 : 3;
    if (irq_at >= 0) begin
      if (r < 0 || irq_at + 2 < r) r = irq_at + 2;
    end
    return r;
  endfunction

  task automatic run_access(input bit sel, input int req_at, input int irq_at,
                            input bit noise, input int limit,
                            output int rel, output bit start_low);
    bit other;
    other = ~sel;
    @(negedge clk);
    ctl_sel = sel;
    if (req_at == REQ_PRE) begin
      ctl_dreq[sel] = 1'b1;
      repeat (4) @(negedge clk);
    end
    bus_strobe = 1'b1;
    port_hit   = 1'b1;
    if (req_at == 0) ctl_dreq[sel] = 1'b1;
    if (irq_at == 0) ctl_irq[sel]  = 1'b1;
    #1;
    start_low = !nrdy;
    rel = -1;
    if (!start_low) begin
      rel = 0;
    end else begin
      for (int e = 1; e <= limit; e++) begin
        @(negedge clk);
        if (nrdy) begin
          rel = e;
          break;
        end
        if (e == req_at) ctl_dreq[sel] = 1'b1;
        if (e == irq_at) ctl_irq[sel]  = 1'b1;
        if (noise) begin
          ctl_dreq[other] = 1'($urandom % 2);
          ctl_irq[other]  = 1'($urandom % 2);
        end
      end
    end
    bus_strobe = 1'b0;
    port_hit   = 1'b0;
    ctl_dreq   = '0;
    ctl_irq    = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_setup();
    @(negedge clk);
    setup_wr = 1'b1;
    @(negedge clk);
    setup_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int rel;
    bit sl;
    void'($urandom(32'h1a2b3c4d));
    rst_ni     = 1'b0;
    bus_strobe = 1'b0;
    port_hit   = 1'b0;
    ctl_sel    = '0;
    ctl_dreq   = '0;
    ctl_irq    = '0;
    setup_wr   = 1'b0;
    repeat (3) @(negedge clk);
    check_int(int'(nrdy), 1, "R9", "nrdy during reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R7: no active cycle
    bus_strobe = 1'b1; port_hit = 1'b0;
    repeat (3) @(negedge clk);
    check_int(int'(nrdy), 1, "R7", "strobe without decode");
    bus_strobe = 1'b0; port_hit = 1'b1;
    #1;
    check_int(int'(nrdy), 1, "R7", "decode without strobe");
    port_hit = 1'b0;

    // R2: request already present before the cycle
    run_access(1'b0, REQ_PRE, IRQ_NONE, 1'b0, 50, rel, sl);
    check_int(int'(sl), 1, "R1", "stall at cycle start");
    check_int(rel, exp_rel(REQ_PRE, IRQ_NONE, 0), "R2", "release edge, early request");

    // R8: next access must wait for a fresh request
    run_access(1'b0, REQ_NONE, IRQ_NONE, 1'b0, 20, rel, sl);
    check_int(rel, -1, "R8", "no reuse of previous request");

    // R1: long stall, request arrives late
    run_access(1'b1, 60, IRQ_NONE, 1'b0, 120, rel, sl);
    check_int(rel, exp_rel(60, IRQ_NONE, 0), "R1", "release after long stall");

    // R3: other controller toggles freely
    run_access(1'b0, 4, IRQ_NONE, 1'b1, 50, rel, sl);
    check_int(rel, exp_rel(4, IRQ_NONE, 0), "R3", "sel0 with noise on ctl1");
    run_access(1'b1, REQ_NONE, IRQ_NONE, 1'b1, 25, rel, sl);
    check_int(rel, -1, "R3", "sel1 ignores ctl0 lines");

    // R4: interrupt mid-stall
    run_access(1'b1, REQ_NONE, 6, 1'b0, 50, rel, sl);
    check_int(rel, exp_rel(REQ_NONE, 6, 0), "R4", "irq release edge");

    // R5: back-to-back accesses after abort
    for (int i = 0; i < 3; i++) begin
      run_access(1'(i % 2), REQ_NONE, IRQ_NONE, 1'b0, 20, rel, sl);
      check_int(rel, exp_rel(REQ_NONE, IRQ_NONE, 1), "R5", "no stall after abort");
    end

    // R6: setup strobe restores waiting
    pulse_setup();
    run_access(1'b0, 3, IRQ_NONE, 1'b0, 50, rel, sl);
    check_int(int'(sl), 1, "R6", "stall resumes after clear");
    check_int(rel, exp_rel(3, IRQ_NONE, 0), "R6", "release edge after clear");

    // R4: interrupt during the wait-state count
    run_access(1'b0, 2, 3, 1'b0, 50, rel, sl);
    check_int(rel, exp_rel(2, 3, 0), "R4", "irq during count");
    pulse_setup();

    // Random accesses
    for (int i = 0; i < 24; i++) begin
      bit s;
      int ra;
      s  = 1'($urandom % 2);
      ra = int'($urandom % 17) - 1;
      run_access(s, ra, IRQ_NONE, 1'b1, 60, rel, sl);
      check_int(rel, exp_rel(ra, IRQ_NONE, 0), "R2", "random access release");
    end

    // R9: reset clears a pending abort
    run_access(1'b0, REQ_NONE, 1, 1'b0, 50, rel, sl);
    check_int(rel, exp_rel(REQ_NONE, 1, 0), "R4", "irq at offset 1");
    do_reset();
    run_access(1'b0, 2, IRQ_NONE, 1'b0, 50, rel, sl);
    check_int(rel, exp_rel(2, IRQ_NONE, 0), "R9", "abort cleared by reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule